// File: doc/BRIEF.md
# Contact Card Slot Power Sequencer

This block is the mode and power sequencing state machine for one contact card slot. It runs through idle, sleep, ramp-up, live, ramp-down and wake-up states. On the way in and out it switches a set of card-side enables in a fixed order: the charge pump, the card supply, the release of the data lines, the card clock and the card reset. All step timing is counted in half-periods of a slow time unit T. `HALF_T_CYCLES` system clocks make one half-period, so a test run can use a very short T.

The host requests a session by pulling `cmd_n` low while `mode` is high, and ends it by raising `cmd_n`. Pulling `mode` low ends any session and puts the slot to sleep. Four fault inputs start an emergency ramp-down: overcurrent, card missing, supply low and overtemperature. A fault also latches the active-low interrupt `irq_n`. The host reset line `host_rst` has two roles. During the last part of ramp-up it starts the card clock. Once the slot is live it drives the card reset, inverted.

Top module: `card_slot_sequencer`

## Requirements
- R1: During and right after reset, all five enables (`pump_en`, `vcc_en`, `io_rel`, `clk_en`, `card_rst`) are 0 and `irq_n` is 1.
- R2: In idle with `mode`=1, `cmd_n`=0, the card present and no latched interrupt, ramp-up starts and `pump_en` is 1 one cycle later. Pulling `mode` high while `cmd_n` is already low also starts it, once the wake-up wait has passed.
- R3: Take H = `HALF_T_CYCLES` and let ramp-up start at the edge where `pump_en` rises. `vcc_en` then rises 3H cycles later. `io_rel` rises 8H cycles later. The slot goes live 14H cycles later.
- R4: Between 8H and 14H, `clk_en` stays 0 until `host_rst` has been seen at 1. It rises one cycle after that and then stays high. At 14H `clk_en` is 1 whatever `host_rst` has done.
- R5: While live, `card_rst` equals the inverse of `host_rst`, one cycle late.
- R6: Ramp-down begins the cycle after it is triggered. `card_rst` goes to 0 at once. `clk_en` goes to 0 after H cycles, `io_rel` after 2H, `vcc_en` after 3H and `pump_en` after 10H. The slot then enters idle, or sleep if `mode` is 0.
- R7: `mode`=0 during a session causes a ramp-down and then sleep. While `mode` is 0, no ramp-up starts.
- R8: After `mode` rises in sleep, the block waits `WAKE_TICKS`*H cycles before it reaches idle. If `mode` falls during that wait, the block goes back to sleep.
- R9: Any fault during ramp-up or live drives `irq_n` to 0 one cycle later and starts a ramp-down. `irq_n` returns to 1 only in idle, with `cmd_n`=1 and the card present. While `irq_n` is 0, no ramp-up starts.
- R10: Card absence (`card_present`=0) drives `irq_n` to 0 in every state, and `irq_n` stays 0 while the card is absent.
- R11: In idle, overcurrent, supply-low and overtemperature have no effect on `irq_n`.
- R12: When ramp-up is aborted, an enable that has not yet turned on stays off through the whole ramp-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_n | input | 1 | Session request, active low |
| mode | input | 1 | 1 = normal operation, 0 = sleep |
| host_rst | input | 1 | Host reset line: starts the clock in ramp-up, drives the card reset while live |
| card_present | input | 1 | 1 = card in slot |
| fault_ovc | input | 1 | Card supply overcurrent |
| fault_supply | input | 1 | Host supply low |
| fault_temp | input | 1 | Overtemperature |
| pump_en | output | 1 | Charge pump enable |
| vcc_en | output | 1 | Card supply enable |
| io_rel | output | 1 | 1 = data lines released, 0 = held low |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset output |
| irq_n | output | 1 | Fault interrupt, active low |

## Verification
A reference model tracks elapsed cycles rather than steps and is compared with every output on each clock. It runs four kinds of session. In the first, `host_rst` rises inside the release window; in the second it never rises. Comparing these two shows clock gating apart from the forced clock start at 14H. Ending one session through `cmd_n` and another through `mode` shows the return to idle apart from the path through sleep and wake-up. A fault injected before the card supply is up shows whether an aborted ramp-up holds its unreached enables off. A fault injected while live, together with card removal and insertion in idle, shows the interrupt release rule apart from the rule that keeps the interrupt low while the card is absent.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SLEEP = 3'd1,
    ST_RAMP  = 3'd2,
    ST_LIVE  = 3'd3,
    ST_DRAIN = 3'd4,
    ST_WAKE  = 3'd5
  } seq_state_e;

  // ramp-up milestones, in half-periods of T after pump start
  localparam int RAMP_VCC  = 3;
  localparam int RAMP_REL  = 8;
  localparam int RAMP_DONE = 14;

  // ramp-down milestones, in half-periods of T after trigger
  localparam int DRAIN_CLK  = 1;
  localparam int DRAIN_IO   = 2;
  localparam int DRAIN_VCC  = 3;
  localparam int DRAIN_DONE = 10;

  function automatic int step_width(input int wake_ticks);
    int top;
    top = (wake_ticks > RAMP_DONE) ? wake_ticks : RAMP_DONE;
    return $clog2(top + 1);
  endfunction

endpackage

// File: rtl/slot_half_tick.sv
module slot_half_tick #(
  parameter int HALF_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run || restart) cnt_d = '0;
    else if (tick)       cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/slot_fault_latch.sv
module slot_fault_latch
  import slot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e st_q,
  input  logic       cmd_n,
  input  logic       card_present,
  input  logic       fault_any,
  output logic       flt_q
);
  logic flt_set, flt_clr, flt_d;
  logic in_session;

  assign in_session = (st_q == ST_RAMP) || (st_q == ST_LIVE);
  assign flt_set    = !card_present || (fault_any && in_session);
  assign flt_clr    = (st_q == ST_IDLE) && cmd_n && card_present;

  always_comb begin
    if (flt_set)      flt_d = 1'b1;
    else if (flt_clr) flt_d = 1'b0;
    else              flt_d = flt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= 1'b0;
    else        flt_q <= flt_d;
  end
endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm
  import slot_seq_pkg::*;
#(
  parameter int WAKE_TICKS = 96,
  parameter int SW = step_width(WAKE_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_n,
  input  logic          mode,
  input  logic          card_present,
  input  logic          fault_any,
  input  logic          flt_q,
  input  logic          tick,
  output seq_state_e    st_q,
  output seq_state_e    st_d,
  output logic [SW-1:0] step_d,
  output logic          timed,
  output logic          restart
);
  localparam logic [SW-1:0] RAMP_END  = SW'(RAMP_DONE);
  localparam logic [SW-1:0] DRAIN_END = SW'(DRAIN_DONE);
  localparam logic [SW-1:0] WAKE_END  = SW'(WAKE_TICKS);

  logic [SW-1:0] step_q, step_nx;
  logic          stop_req, go_req;

  assign step_nx  = step_q + 1'b1;
  assign stop_req = fault_any || cmd_n || !mode;
  assign go_req   = mode && !cmd_n && !flt_q && card_present;
  assign timed    = (st_q == ST_RAMP) || (st_q == ST_DRAIN) || (st_q == ST_WAKE);
  assign restart  = (st_d != st_q);

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!mode) st_d = ST_SLEEP;
        else if (go_req) begin
          st_d   = ST_RAMP;
          step_d = '0;
        end
      end
      ST_RAMP: begin
        if (stop_req) begin
          st_d   = ST_DRAIN;
          step_d = '0;
        end else if (tick) begin
          step_d = step_nx;
          if (step_nx == RAMP_END) st_d = ST_LIVE;
        end
      end
      ST_LIVE: begin
        if (stop_req) begin
          st_d   = ST_DRAIN;
          step_d = '0;
        end
      end
      ST_DRAIN: begin
        if (tick) begin
          step_d = step_nx;
          if (step_nx == DRAIN_END) st_d = mode ? ST_IDLE : ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (mode) begin
          st_d   = ST_WAKE;
          step_d = '0;
        end
      end
      ST_WAKE: begin
        if (!mode) st_d = ST_SLEEP;
        else if (tick) begin
          step_d = step_nx;
          if (step_nx == WAKE_END) st_d = ST_IDLE;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        step_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end
endmodule

// File: rtl/slot_out_stage.sv
module slot_out_stage
  import slot_seq_pkg::*;
#(
  parameter int SW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    st_d,
  input  logic [SW-1:0] step_d,
  input  logic          host_rst,
  output logic          pump_q,
  output logic          vcc_q,
  output logic          io_q,
  output logic          clk_q,
  output logic          rst_q
);
  localparam logic [SW-1:0] UP_VCC = SW'(RAMP_VCC);
  localparam logic [SW-1:0] UP_REL = SW'(RAMP_REL);
  localparam logic [SW-1:0] DN_CLK = SW'(DRAIN_CLK);
  localparam logic [SW-1:0] DN_IO  = SW'(DRAIN_IO);
  localparam logic [SW-1:0] DN_VCC = SW'(DRAIN_VCC);

  logic pump_d, vcc_d, io_d, clk_d, rst_d;

  always_comb begin
    pump_d = 1'b0;
    vcc_d  = 1'b0;
    io_d   = 1'b0;
    clk_d  = 1'b0;
    rst_d  = 1'b0;
    unique case (st_d)
      ST_RAMP: begin
        pump_d = 1'b1;
        vcc_d  = (step_d >= UP_VCC);
        io_d   = (step_d >= UP_REL);
        clk_d  = (step_d >= UP_REL) && (clk_q || host_rst);
      end
      ST_LIVE: begin
        pump_d = 1'b1;
        vcc_d  = 1'b1;
        io_d   = 1'b1;
        clk_d  = 1'b1;
        rst_d  = !host_rst;
      end
      ST_DRAIN: begin
        // each line only falls; a line never raised stays low
        pump_d = 1'b1;
        vcc_d  = vcc_q && (step_d < DN_VCC);
        io_d   = io_q  && (step_d < DN_IO);
        clk_d  = clk_q && (step_d < DN_CLK);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_q <= 1'b0;
      vcc_q  <= 1'b0;
      io_q   <= 1'b0;
      clk_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      pump_q <= pump_d;
      vcc_q  <= vcc_d;
      io_q   <= io_d;
      clk_q  <= clk_d;
      rst_q  <= rst_d;
    end
  end
endmodule

// File: rtl/card_slot_sequencer.sv
module card_slot_sequencer
  import slot_seq_pkg::*;
#(
  parameter int HALF_T_CYCLES = 32,
  parameter int WAKE_TICKS    = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_n,
  input  logic mode,
  input  logic host_rst,
  input  logic card_present,
  input  logic fault_ovc,
  input  logic fault_supply,
  input  logic fault_temp,
  output logic pump_en,
  output logic vcc_en,
  output logic io_rel,
  output logic clk_en,
  output logic card_rst,
  output logic irq_n
);
  localparam int SW = step_width(WAKE_TICKS);

  seq_state_e    st_q, st_d;
  logic [SW-1:0] step_d;
  logic          timed, restart, tick;
  logic          fault_any, flt_q;

  assign fault_any = fault_ovc || fault_supply || fault_temp || !card_present;

  slot_half_tick #(.HALF_CYCLES(HALF_T_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timed),
    .restart (restart),
    .tick    (tick)
  );

  slot_seq_fsm #(.WAKE_TICKS(WAKE_TICKS), .SW(SW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_n        (cmd_n),
    .mode         (mode),
    .card_present (card_present),
    .fault_any    (fault_any),
    .flt_q        (flt_q),
    .tick         (tick),
    .st_q         (st_q),
    .st_d         (st_d),
    .step_d       (step_d),
    .timed        (timed),
    .restart      (restart)
  );

  slot_fault_latch u_flt (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_q         (st_q),
    .cmd_n        (cmd_n),
    .card_present (card_present),
    .fault_any    (fault_any),
    .flt_q        (flt_q)
  );

  slot_out_stage #(.SW(SW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_d     (st_d),
    .step_d   (step_d),
    .host_rst (host_rst),
    .pump_q   (pump_en),
    .vcc_q    (vcc_en),
    .io_q     (io_rel),
    .clk_q    (clk_en),
    .rst_q    (card_rst)
  );

  assign irq_n = !flt_q;
endmodule

// File: rtl/card_slot_sequencer_checker.sv
module card_slot_sequencer_checker (
  input logic clk,
  input logic rst_n,
  input logic mode,
  input logic card_present,
  input logic pump_en,
  input logic vcc_en,
  input logic io_rel,
  input logic clk_en,
  input logic card_rst,
  input logic irq_n
);
  // R3: the supply only runs while the pump does
  a_r3_vcc_under_pump: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_en |-> pump_en);

  // R3: data lines are released only with the supply up
  a_r3_io_under_vcc: assert property (@(posedge clk) disable iff (!rst_n)
    io_rel |-> vcc_en);

  // R4: the clock runs only with the data lines released
  a_r4_clk_under_io: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_rel);

  // R5: the card reset is driven only with the clock running
  a_r5_rst_under_clk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> clk_en);

  // R6: the pump is the last enable to fall
  a_r6_pump_falls_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pump_en) |-> !vcc_en);

  // R7: no ramp-up starts while mode is low
  a_r7_no_start_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !pump_en) |=> !pump_en);

  // R9: a pending interrupt blocks ramp-up
  a_r9_irq_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !pump_en) |=> !pump_en);

  // R10: a missing card pulls the interrupt low
  a_r10_absent_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !card_present |=> !irq_n);
endmodule

bind card_slot_sequencer card_slot_sequencer_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .card_present (card_present),
  .pump_en      (pump_en),
  .vcc_en       (vcc_en),
  .io_rel       (io_rel),
  .clk_en       (clk_en),
  .card_rst     (card_rst),
  .irq_n        (irq_n)
);

// File: tb/card_slot_sequencer_test.sv
`timescale 1ns/1ps
module card_slot_sequencer_test;
  localparam int H = 4;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n, cmd_n, mode, host_rst, card_present;
  logic fault_ovc, fault_supply, fault_temp;
  logic pump_en, vcc_en, io_rel, clk_en, card_rst, irq_n;

  int checks = 0;
  int errors = 0;
  int tnow   = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  card_slot_sequencer #(.HALF_T_CYCLES(H), .WAKE_TICKS(W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .mode(mode), .host_rst(host_rst),
    .card_present(card_present), .fault_ovc(fault_ovc), .fault_supply(fault_supply),
    .fault_temp(fault_temp), .pump_en(pump_en), .vcc_en(vcc_en), .io_rel(io_rel),
    .clk_en(clk_en), .card_rst(card_rst), .irq_n(irq_n)
  );

  // reference model: state code and elapsed cycles since entering a timed state
  int m_st, m_cyc;
  bit m_pump, m_vcc, m_io, m_clk, m_rst, m_flt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cyc = 0;
      m_pump = 0; m_vcc = 0; m_io = 0; m_clk = 0; m_rst = 0; m_flt = 0;
    end else begin
      bit flt_in, fl_nx;
      int ns, nc;
      flt_in = fault_ovc | fault_supply | fault_temp | !card_present;
      fl_nx = m_flt;
      if (!card_present || (flt_in && (m_st == 2 || m_st == 3))) fl_nx = 1;
      else if (m_st == 0 && cmd_n) fl_nx = 0;
      ns = m_st; nc = m_cyc + 1;
      case (m_st)
        0: if (!mode) ns = 1;
           else if (!cmd_n && !m_flt && card_present) begin ns = 2; nc = 0; end
        2: if (flt_in || cmd_n || !mode) begin ns = 4; nc = 0; end
           else if (nc == 14*H) ns = 3;
        3: if (flt_in || cmd_n || !mode) begin ns = 4; nc = 0; end
        4: if (nc == 10*H) ns = mode ? 0 : 1;
        1: if (mode) begin ns = 5; nc = 0; end
        5: if (!mode) ns = 1;
           else if (nc == W*H) ns = 0;
        default: ns = 0;
      endcase
      m_pump = (ns == 2 || ns == 3 || ns == 4);
      m_vcc  = (ns == 2) ? (nc >= 3*H) : (ns == 3) ? 1'b1 : (ns == 4) ? (m_vcc && nc < 3*H) : 1'b0;
      m_io   = (ns == 2) ? (nc >= 8*H) : (ns == 3) ? 1'b1 : (ns == 4) ? (m_io && nc < 2*H) : 1'b0;
      m_clk  = (ns == 2) ? (nc >= 8*H && (m_clk || host_rst)) : (ns == 3) ? 1'b1 :
               (ns == 4) ? (m_clk && nc < H) : 1'b0;
      m_rst  = (ns == 3) && !host_rst;
      m_flt  = fl_nx;
      m_st = ns; m_cyc = nc;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at t=%0d", tag, act, exp, tnow);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R2 R6 model pump_en", pump_en, m_pump);
      chk("R3 R12 model vcc_en", vcc_en, m_vcc);
      chk("R3 R6 model io_rel", io_rel, m_io);
      chk("R4 model clk_en", clk_en, m_clk);
      chk("R5 model card_rst", card_rst, m_rst);
      chk("R9 R10 model irq_n", irq_n, !m_flt);
    end
  end

  task automatic go(input int t);
    while (tnow < t) begin
      @(negedge clk);
      tnow++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int b, b2, b3, b4, b5, b6;
    rst_n = 0; cmd_n = 1; mode = 1; host_rst = 0; card_present = 1;
    fault_ovc = 0; fault_supply = 0; fault_temp = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pump_en", pump_en, 0); chk("R1 vcc_en", vcc_en, 0);
    chk("R1 clk_en", clk_en, 0); chk("R1 irq_n", irq_n, 1);
    rst_n = 1;
    go(2);
    chk("R1 card_rst", card_rst, 0); chk("R1 io_rel", io_rel, 0);

    // session 1: host_rst starts clock in window, ended by cmd_n
    b = 5; go(b); cmd_n = 0;
    go(b+1);  chk("R2 pump_en", pump_en, 1);
    go(b+12); chk("R3 vcc_en early", vcc_en, 0);
    go(b+13); chk("R3 vcc_en", vcc_en, 1);
    go(b+32); chk("R3 io_rel early", io_rel, 0);
    go(b+33); chk("R3 io_rel", io_rel, 1); chk("R4 clk gated", clk_en, 0);
    go(b+41); host_rst = 1;
    go(b+42); chk("R4 clk by host_rst", clk_en, 1);
    go(b+57); chk("R5 card_rst inverse", card_rst, 0); host_rst = 0;
    go(b+58); chk("R5 card_rst follow", card_rst, 1);
    go(b+60); cmd_n = 1;
    go(b+61); chk("R6 card_rst drop", card_rst, 0); chk("R6 clk held", clk_en, 1);
    go(b+65); chk("R6 clk stop", clk_en, 0);
    go(b+72); chk("R6 vcc held", vcc_en, 1);
    go(b+73); chk("R6 vcc off", vcc_en, 0);
    go(b+100); chk("R6 pump held", pump_en, 1);
    go(b+101); chk("R6 pump off", pump_en, 0);

    // session 2: host_rst never high, ended by mode
    b = b + 105; go(b); cmd_n = 0;
    go(b+56); chk("R4 clk still gated", clk_en, 0);
    go(b+57); chk("R4 clk forced live", clk_en, 1); chk("R5 card_rst high", card_rst, 1);
    go(b+60); mode = 0;
    go(b+101); chk("R7 pump off", pump_en, 0);
    go(b+110); chk("R7 no start asleep", pump_en, 0);

    // wake with cmd_n already low
    b2 = b + 110; mode = 1;
    go(b2+25); chk("R8 still waking", pump_en, 0);
    go(b2+26); chk("R8 R2 start after wake", pump_en, 1);

    // abort before supply up
    b3 = b2 + 26;
    go(b3+4); fault_ovc = 1;
    go(b3+5); chk("R9 irq low", irq_n, 0);
    go(b3+10); fault_ovc = 0;
    go(b3+20); chk("R12 vcc stays off", vcc_en, 0); chk("R12 io stays off", io_rel, 0);
    go(b3+55); chk("R9 blocked", pump_en, 0); chk("R9 irq held", irq_n, 0); cmd_n = 1;
    go(b3+56); chk("R9 irq release", irq_n, 1);

    // card absent in idle
    b4 = b3 + 60; go(b4); card_present = 0;
    go(b4+1); chk("R10 irq absent", irq_n, 0);
    go(b4+2); cmd_n = 0;
    go(b4+10); chk("R10 no start", pump_en, 0); cmd_n = 1;
    go(b4+20); chk("R10 irq stays low", irq_n, 0); card_present = 1;
    go(b4+22); chk("R10 irq released", irq_n, 1);

    // other faults in idle ignored
    b5 = b4 + 25; go(b5); fault_ovc = 1; fault_supply = 1; fault_temp = 1;
    go(b5+5); chk("R11 irq unaffected", irq_n, 1); chk("R11 pump", pump_en, 0);
    go(b5+6); fault_ovc = 0; fault_supply = 0; fault_temp = 0;

    // fault while live
    b6 = b5 + 8; go(b6); cmd_n = 0;
    go(b6+60); fault_temp = 1;
    go(b6+61); chk("R9 irq live fault", irq_n, 0); chk("R9 card_rst drop", card_rst, 0);
    go(b6+62); fault_temp = 0;
    go(b6+105); cmd_n = 1;
    go(b6+106); chk("R9 irq release live", irq_n, 1);
    go(b6+110);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule